// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the programming face of a four-channel DMA controller. A processor reaches it through a small 8-bit I/O window. Each write or read to an offset in that window lands on one of the block's registers. Every channel owns a 16-bit memory address and a 16-bit transfer count. The processor moves these eight bits at a time, and one low/high byte pointer is shared by all eight of these registers. Beside them the block keeps a mode word for each channel, a four-bit channel mask and a command byte whose disable bit stops all transfer activity.

The transfer engines downstream read the decoded state continuously. They see the base and current copies of every address and count, each channel's transfer type, operating kind, auto-reload flag and address direction, the mask bits, and a global enable. Bus arbitration, the memory cycles themselves and the page extension of addresses lie outside the block.

Offsets in the window: channel n's address is at 2n and its count is at 2n+1 (0..7). Command is at 8, single-mask at 9, mode at 10, byte-pointer clear at 11, clear-mask at 12 and load-all-mask at 13. Offsets 14 and 15 are unused.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, the enable output is 1, and every address, count and mode field is 0.
- R2: A write to offset 2n or 2n+1 stores the data byte into the channel n address or count register respectively. It writes the byte that the pointer selects, and it updates the base copy and the current copy together.
- R3: Every read or write at any of the offsets 0..7 toggles the single shared byte pointer, whichever channel or register the offset belongs to.
- R4: A write of any value to offset 11 returns the byte pointer to the low byte.
- R5: A read at offset 2n or 2n+1 returns the byte of the channel's current address or count that the pointer selects: the low byte when the pointer is clear, and the high byte when it is set.
- R6: A write to offset 10 updates only the channel named in data bits 1-0. Bits 3-2 give the transfer type (00 verify, 01 memory to device, 10 device to memory, 11 illegal). Bit 4 enables auto-reload. Bit 5 set means the address counts down. Bits 7-6 give the kind (00 demand, 01 single, 10 block, 11 cascade). Other channels keep their mode.
- R7: A write to offset 9 sets the mask bit of the channel named in data bits 1-0 to the value of data bit 2. The other mask bits are unchanged.
- R8: A write of any value to offset 12 clears all four mask bits.
- R9: A write to offset 13 loads mask bits 3-0 from data bits 3-0. Bit 0 belongs to channel 0, and 1 means masked.
- R10: A write to offset 8 stores the command byte. The enable output is 0 while command bit 2 is 1 (value 4 disables) and 1 while it is 0 (value 0 enables). A read at offset 8 returns the stored byte.
- R11: Writes to offsets 14 and 15 change no register and leave the byte pointer alone. Reads at offsets 9 to 15 return 0 and leave the byte pointer alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Write strobe for one cycle |
| io_rd | input | 1 | Read strobe for one cycle |
| io_port | input | 4 | Offset in the register window |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid during io_rd |
| base_addr_o | output | 64 | Base address of each channel, channel n at bits 16n+15:16n |
| cur_addr_o | output | 64 | Current address of each channel |
| base_cnt_o | output | 64 | Base count of each channel |
| cur_cnt_o | output | 64 | Current count of each channel |
| xfer_type_o | output | 8 | Transfer type of each channel, 2 bits per channel |
| xfer_kind_o | output | 8 | Operating kind of each channel, 2 bits per channel |
| auto_init_o | output | 4 | Auto-reload flag of each channel |
| addr_dec_o | output | 4 | Address counts down, per channel |
| chan_mask_o | output | 4 | Mask bit of each channel, 1 = masked |
| dma_en_o | output | 1 | Global enable from the command byte |

## Verification
The bench builds the block with its default values: four channels and a 4-bit offset. At these values every channel port, every control port and both unused offsets can be reached with a single write or read. Because the default channel count fills the 2-bit channel fields of the mode and single-mask words exactly, every channel selector code that can be encoded is driven. With the pointer shared and only four channels, the bench can interleave accesses across channels and between address and count. That lets it show that the one pointer carries over between them.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

  localparam int DATA_W = 8;
  localparam int REG_W  = 16;

  // control offsets, relative to the first offset after the channel ports
  localparam int CTL_CMD   = 0;
  localparam int CTL_SMASK = 1;
  localparam int CTL_MODE  = 2;
  localparam int CTL_PCLR  = 3;
  localparam int CTL_MCLR  = 4;
  localparam int CTL_MALL  = 5;
  localparam int CTL_COUNT = 6;

  typedef enum logic [1:0] {
    XF_VERIFY   = 2'b00,
    XF_TO_DEV   = 2'b01,
    XF_FROM_DEV = 2'b10,
    XF_ILLEGAL  = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    KD_DEMAND  = 2'b00,
    KD_SINGLE  = 2'b01,
    KD_BLOCK   = 2'b10,
    KD_CASCADE = 2'b11
  } kind_e;

  // field order matches mode word bits 7..2
  typedef struct packed {
    kind_e kind;
    logic  down;
    logic  reload;
    xfer_e xfer;
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] old,
                                                input logic hi,
                                                input logic [DATA_W-1:0] b);
    logic [REG_W-1:0] r;
    r = old;
    if (hi) r[REG_W-1:DATA_W] = b;
    else    r[DATA_W-1:0]     = b;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] get_byte(input logic [REG_W-1:0] v,
                                                 input logic hi);
    return hi ? v[REG_W-1:DATA_W] : v[DATA_W-1:0];
  endfunction

  function automatic chan_mode_t unpack_mode(input logic [MODE_W-1:0] bits);
    return chan_mode_t'(bits);
  endfunction

endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
  import dmac_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PA_W   = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [PA_W-1:0] io_port,
  output logic            reg_acc,
  output logic            reg_wr,
  output logic            reg_rd,
  output logic [CH_W-1:0] ch_idx,
  output logic            is_cnt,
  output logic            cmd_wr,
  output logic            cmd_rd,
  output logic            smask_wr,
  output logic            mode_wr,
  output logic            ptr_clr,
  output logic            mclr_wr,
  output logic            mall_wr,
  output logic            unused_wr
);

  localparam int CTRL_BASE = 2 * NUM_CH;

  logic is_reg_port;
  logic [CTL_COUNT-1:0] ctl_hit;

  assign is_reg_port = (io_port < PA_W'(CTRL_BASE));
  assign ch_idx      = io_port[CH_W:1];
  assign is_cnt      = io_port[0];

  for (genvar k = 0; k < CTL_COUNT; k++) begin : g_ctl
    assign ctl_hit[k] = (io_port == PA_W'(CTRL_BASE + k));
  end

  assign reg_wr    = io_wr && is_reg_port;
  assign reg_rd    = io_rd && !io_wr && is_reg_port;
  assign reg_acc   = reg_wr || reg_rd;
  assign cmd_wr    = io_wr && ctl_hit[CTL_CMD];
  assign cmd_rd    = io_rd && ctl_hit[CTL_CMD];
  assign smask_wr  = io_wr && ctl_hit[CTL_SMASK];
  assign mode_wr   = io_wr && ctl_hit[CTL_MODE];
  assign ptr_clr   = io_wr && ctl_hit[CTL_PCLR];
  assign mclr_wr   = io_wr && ctl_hit[CTL_MCLR];
  assign mall_wr   = io_wr && ctl_hit[CTL_MALL];
  assign unused_wr = io_wr && !is_reg_port && !(|ctl_hit);

  // R11: at most one write target is decoded per cycle
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, cmd_wr, smask_wr, mode_wr, ptr_clr, mclr_wr, mall_wr, unused_wr}));

endmodule

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  output logic hi
);

  logic hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_q <= 1'b0;
    else if (clr)  hi_q <= 1'b0;
    else if (step) hi_q <= !hi_q;
  end

  assign hi = hi_q;

  // R3: each register access flips the pointer
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (hi != $past(hi)));

  // R4: the clear port returns the pointer to the low byte
  p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hi);

  // R11: without access or clear the pointer holds
  p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(hi));

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic              hi_sel,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_bits,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [REG_W-1:0]  cur_cnt,
  output chan_mode_t        mode
);

  logic [REG_W-1:0] base_addr_q, cur_addr_q, base_cnt_q, cur_cnt_q;
  chan_mode_t       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
    end else if (addr_we) begin
      base_addr_q <= put_byte(base_addr_q, hi_sel, wr_byte);
      cur_addr_q  <= put_byte(cur_addr_q, hi_sel, wr_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt_q <= '0;
      cur_cnt_q  <= '0;
    end else if (cnt_we) begin
      base_cnt_q <= put_byte(base_cnt_q, hi_sel, wr_byte);
      cur_cnt_q  <= put_byte(cur_cnt_q, hi_sel, wr_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= unpack_mode(mode_bits);
  end

  assign base_addr = base_addr_q;
  assign cur_addr  = cur_addr_q;
  assign base_cnt  = base_cnt_q;
  assign cur_cnt   = cur_cnt_q;
  assign mode      = mode_q;

  // R2: a low-byte address write lands in the low byte of the current copy
  p_addr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !hi_sel) |=> (cur_addr[DATA_W-1:0] == $past(wr_byte)));

  // R2: a high-byte count write lands in the high byte of the base copy
  p_cnt_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && hi_sel) |=> (base_cnt[REG_W-1:DATA_W] == $past(wr_byte)));

  // R6: a mode write stores the upper mode bits unchanged
  p_mode_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode == $past(mode_bits)));

  // R6: without a mode write the mode holds
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode));

endmodule

// File: rtl/dmac_mask_ctrl.sv
module dmac_mask_ctrl #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_we,
  input  logic [CH_W-1:0]   single_ch,
  input  logic              single_val,
  input  logic              clear_all,
  input  logic              load_all,
  input  logic [NUM_CH-1:0] load_val,
  output logic [NUM_CH-1:0] mask
);

  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] single_next;

  always_comb begin
    single_next = mask_q;
    single_next[single_ch] = single_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (clear_all) mask_q <= '0;
    else if (load_all)  mask_q <= load_val;
    else if (single_we) mask_q <= single_next;
  end

  assign mask = mask_q;

  // R7: the selected channel takes the written value
  p_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (single_we && !clear_all && !load_all) |=> (mask[$past(single_ch)] == $past(single_val)));

  // R7: exactly the selected bit may change
  p_single_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (single_we && !clear_all && !load_all) |=> ($countones(mask ^ $past(mask)) <= 1));

  // R8: clear-all leaves every channel unmasked
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (mask == '0));

  // R9: load-all copies the written bits
  p_load_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_all && !clear_all) |=> (mask == $past(load_val)));

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PA_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic [PA_W-1:0]         io_port,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  output logic [NUM_CH*16-1:0]    base_addr_o,
  output logic [NUM_CH*16-1:0]    cur_addr_o,
  output logic [NUM_CH*16-1:0]    base_cnt_o,
  output logic [NUM_CH*16-1:0]    cur_cnt_o,
  output logic [NUM_CH*2-1:0]     xfer_type_o,
  output logic [NUM_CH*2-1:0]     xfer_kind_o,
  output logic [NUM_CH-1:0]       auto_init_o,
  output logic [NUM_CH-1:0]       addr_dec_o,
  output logic [NUM_CH-1:0]       chan_mask_o,
  output logic                    dma_en_o
);

  localparam int CH_W    = $clog2(NUM_CH);
  localparam int OFF_BIT = 2;  // command bit that stops all transfers

  // decoded events, named for the assertions
  logic            reg_acc, reg_wr, reg_rd, is_cnt;
  logic [CH_W-1:0] ch_idx;
  logic            cmd_wr, cmd_rd, smask_wr, mode_wr, ptr_clr, mclr_wr, mall_wr, unused_wr;
  logic            ptr_hi;
  logic [DATA_W-1:0] cmd_q;

  logic [REG_W-1:0] cur_addr_a [NUM_CH];
  logic [REG_W-1:0] cur_cnt_a  [NUM_CH];

  dmac_port_decode #(.NUM_CH(NUM_CH), .PA_W(PA_W)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .reg_acc(reg_acc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .ch_idx(ch_idx), .is_cnt(is_cnt),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .smask_wr(smask_wr), .mode_wr(mode_wr),
    .ptr_clr(ptr_clr), .mclr_wr(mclr_wr), .mall_wr(mall_wr), .unused_wr(unused_wr)
  );

  dmac_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .step(reg_acc), .clr(ptr_clr), .hi(ptr_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic       addr_we_c, cnt_we_c, mode_we_c;
    chan_mode_t mode_c;

    assign addr_we_c = reg_wr && !is_cnt && (ch_idx == CH_W'(c));
    assign cnt_we_c  = reg_wr &&  is_cnt && (ch_idx == CH_W'(c));
    assign mode_we_c = mode_wr && (io_wdata[CH_W-1:0] == CH_W'(c));

    dmac_chan_regs u_chan (
      .clk(clk), .rst_n(rst_n),
      .addr_we(addr_we_c), .cnt_we(cnt_we_c), .hi_sel(ptr_hi), .wr_byte(io_wdata),
      .mode_we(mode_we_c), .mode_bits(io_wdata[DATA_W-1:DATA_W-MODE_W]),
      .base_addr(base_addr_o[c*REG_W +: REG_W]),
      .cur_addr(cur_addr_a[c]),
      .base_cnt(base_cnt_o[c*REG_W +: REG_W]),
      .cur_cnt(cur_cnt_a[c]),
      .mode(mode_c)
    );

    assign cur_addr_o[c*REG_W +: REG_W] = cur_addr_a[c];
    assign cur_cnt_o[c*REG_W +: REG_W]  = cur_cnt_a[c];
    assign xfer_type_o[c*2 +: 2] = mode_c.xfer;
    assign xfer_kind_o[c*2 +: 2] = mode_c.kind;
    assign auto_init_o[c]        = mode_c.reload;
    assign addr_dec_o[c]         = mode_c.down;
  end

  dmac_mask_ctrl #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .single_we(smask_wr), .single_ch(io_wdata[CH_W-1:0]), .single_val(io_wdata[CH_W]),
    .clear_all(mclr_wr), .load_all(mall_wr), .load_val(io_wdata[NUM_CH-1:0]),
    .mask(chan_mask_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= io_wdata;
  end

  assign dma_en_o = !cmd_q[OFF_BIT];

  always_comb begin
    io_rdata = '0;
    if (reg_rd)
      io_rdata = get_byte(is_cnt ? cur_cnt_a[ch_idx] : cur_addr_a[ch_idx], ptr_hi);
    else if (cmd_rd)
      io_rdata = cmd_q;
  end

  // R10: writing the disable bit drops the enable
  p_cmd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && io_wdata[OFF_BIT]) |=> !dma_en_o);

  // R10: writing with the disable bit clear raises the enable
  p_cmd_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !io_wdata[OFF_BIT]) |=> dma_en_o);

  // R11: unused offsets touch neither mask nor command
  p_unused_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unused_wr |=> ($stable(chan_mask_o) && $stable(dma_en_o) && $stable(cur_addr_o)));

  // R11: reads outside the readable ports return zero
  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && !reg_rd && !cmd_rd) |-> (io_rdata == '0));

endmodule

// File: tb/test_dmac_regfile.sv
module test_dmac_regfile;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0] io_port = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [NCH*16-1:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
  logic [NCH*2-1:0]  xfer_type_o, xfer_kind_o;
  logic [NCH-1:0]    auto_init_o, addr_dec_o, chan_mask_o;
  logic              dma_en_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] e_addr [NCH];
  logic [15:0] e_cnt  [NCH];

  always #5 clk = !clk;

  dmac_regfile i_dmac_regfile (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
    .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o),
    .xfer_type_o(xfer_type_o), .xfer_kind_o(xfer_kind_o),
    .auto_init_o(auto_init_o), .addr_dec_o(addr_dec_o),
    .chan_mask_o(chan_mask_o), .dma_en_o(dma_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    io_wr = 1'b1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p, output logic [7:0] d);
    io_rd = 1'b1; io_port = p;
    #2 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " base addr"}, 32'(base_addr_o[c*16 +: 16]), 32'(e_addr[c]));
      chk({tag, " cur addr"},  32'(cur_addr_o[c*16 +: 16]),  32'(e_addr[c]));
      chk({tag, " base cnt"},  32'(base_cnt_o[c*16 +: 16]),  32'(e_cnt[c]));
      chk({tag, " cur cnt"},   32'(cur_cnt_o[c*16 +: 16]),   32'(e_cnt[c]));
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 mask", 32'(chan_mask_o), 32'hF);
    chk("R1 enable", 32'(dma_en_o), 32'd1);
    chk("R1 modes", 32'({xfer_type_o, xfer_kind_o, auto_init_o, addr_dec_o}), 32'd0);
    check_regs("R1");
    rd(4'd0, d);
    chk("R1 read after reset", 32'(d), 32'd0);
    wr(4'd11, 8'h00);
  endtask

  task automatic t_program;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] a, n;
      a = 16'hA0B0 ^ 16'(c * 16'h1111);
      n = 16'h0120 + 16'(c * 16'h0203);
      wr(4'(2*c), a[7:0]);   wr(4'(2*c), a[15:8]);
      wr(4'(2*c+1), n[7:0]); wr(4'(2*c+1), n[15:8]);
      e_addr[c] = a; e_cnt[c] = n;
    end
    check_regs("R2 program");
  endtask

  task automatic t_shared_ptr;
    logic [7:0] d;
    wr(4'd11, 8'h00);
    wr(4'd0, 8'hAA);          // low byte of ch0 address
    wr(4'd3, 8'h55);          // pointer now high: ch1 count high byte
    e_addr[0][7:0] = 8'hAA;
    e_cnt[1][15:8] = 8'h55;
    check_regs("R3 shared pointer");
    rd(4'd0, d);
    chk("R5 low byte read", 32'(d), 32'(e_addr[0][7:0]));
    rd(4'd0, d);
    chk("R5 high byte read", 32'(d), 32'(e_addr[0][15:8]));
    rd(4'd7, d);
    chk("R5 count low read", 32'(d), 32'(e_cnt[3][7:0]));
    wr(4'd6, 8'h3C);          // read toggled the pointer: high byte of ch3 address
    e_addr[3][15:8] = 8'h3C;
    check_regs("R3 read toggles pointer");
  endtask

  task automatic t_ptr_clear;
    wr(4'd11, 8'h00);
    wr(4'd2, 8'h11);          // pointer now high
    wr(4'd11, 8'h9E);         // any value clears
    wr(4'd2, 8'h77);          // low byte again
    e_addr[1][7:0] = 8'h77;
    check_regs("R4 pointer clear");
    wr(4'd11, 8'h00);
  endtask

  task automatic t_mode;
    wr(4'd10, 8'b10_1_1_01_10);   // ch2: block, down, reload, to device
    chk("R6 ch2 type", 32'(xfer_type_o[5:4]), 32'b01);
    chk("R6 ch2 kind", 32'(xfer_kind_o[5:4]), 32'b10);
    chk("R6 ch2 reload", 32'(auto_init_o[2]), 32'd1);
    chk("R6 ch2 down", 32'(addr_dec_o[2]), 32'd1);
    chk("R6 others untouched", 32'({xfer_type_o[3:0], xfer_type_o[7:6], auto_init_o[1:0]}), 32'd0);
    wr(4'd10, 8'b11_0_0_11_01);   // ch1: cascade, up, no reload, illegal
    chk("R6 ch1 fields", 32'({xfer_kind_o[3:2], addr_dec_o[1], auto_init_o[1], xfer_type_o[3:2]}), 32'b11_0_0_11);
    chk("R6 ch2 kept", 32'({xfer_kind_o[5:4], addr_dec_o[2], auto_init_o[2], xfer_type_o[5:4]}), 32'b10_1_1_01);
    wr(4'd10, 8'b01_0_1_10_11);   // ch3: single, reload, from device
    chk("R6 ch3 fields", 32'({xfer_kind_o[7:6], addr_dec_o[3], auto_init_o[3], xfer_type_o[7:6]}), 32'b01_0_1_10);
  endtask

  task automatic t_mask;
    wr(4'd9, 8'b0000_0_01);
    chk("R7 clear ch1", 32'(chan_mask_o), 32'b1101);
    wr(4'd9, 8'b0000_0_11);
    chk("R7 clear ch3", 32'(chan_mask_o), 32'b0101);
    wr(4'd9, 8'b0000_1_01);
    chk("R7 set ch1", 32'(chan_mask_o), 32'b0111);
    wr(4'd12, 8'hA5);
    chk("R8 clear all", 32'(chan_mask_o), 32'b0000);
    wr(4'd13, 8'hF6);
    chk("R9 load all", 32'(chan_mask_o), 32'b0110);
    wr(4'd13, 8'h09);
    chk("R9 load all again", 32'(chan_mask_o), 32'b1001);
  endtask

  task automatic t_command;
    logic [7:0] d;
    wr(4'd8, 8'h04);
    chk("R10 disable", 32'(dma_en_o), 32'd0);
    rd(4'd8, d);
    chk("R10 readback", 32'(d), 32'h04);
    wr(4'd8, 8'h00);
    chk("R10 enable", 32'(dma_en_o), 32'd1);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    logic [3:0] m;
    m = chan_mask_o;
    wr(4'd11, 8'h00);
    wr(4'd14, 8'hFF);
    wr(4'd15, 8'hFF);
    rd(4'd15, d);
    chk("R11 read unused", 32'(d), 32'd0);
    rd(4'd9, d);
    chk("R11 read control", 32'(d), 32'd0);
    chk("R11 mask kept", 32'(chan_mask_o), 32'(m));
    chk("R11 enable kept", 32'(dma_en_o), 32'd1);
    wr(4'd4, 8'hE1);          // pointer must still be low
    e_addr[2][7:0] = 8'hE1;
    check_regs("R11 pointer untouched");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin e_addr[c] = '0; e_cnt[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_shared_ptr;
    t_ptr_clear;
    t_mode;
    t_mask;
    t_command;
    t_unused;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule